// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits at the output of a video digitizer. It takes one stream of samples per sample clock. Each sample carries several colour channels of fixed width. The block sends the stream to output port A only, or splits it across ports A and B. When both ports are used, the samples can appear one port at a time (interleaved) or as even/odd pairs that update together (parallel). A steering bit picks which port gets the even samples. The even/odd count restarts on the leading edge of the horizontal sync input.

Every sample passes through a delay line of fixed depth before it reaches a port, so the output latency is known in each mode. The block also produces a data clock. Port data changes on the falling edge of that clock, so a receiver captures on the rising edge. A power-enable input lets the block drive the ports or float them. A valid flag for each port stays low until the pipeline has refilled after reset or after any change of mode.

Top module: `pixel_port_demux`

## Requirements
- R1: With portMode = 0 (single port), port A presents each sample exactly PIPE clocks after it was captured, and validB stays low. dataClk is the inverted sample clock, so it is high while clk is low.
- R2: The first rising clk edge at which hsyncIn is sampled high after being sampled low captures sample index 0 (even). Indices then alternate odd/even on each clock until the next leading edge.
- R3: With swapPhase = 0, even samples are routed to port A and odd samples to port B. With swapPhase = 1, the routing is reversed.
- R4: With portMode = 1 and pairMode = 0 (interleaved), each sample appears on its port PIPE clocks after capture. The other port holds its value, so the two ports never change on the same clock.
- R5: With portMode = 1 and pairMode = 1 (parallel), ports A and B update together on the clock that presents an odd sample, PIPE clocks after that sample's capture. The even partner is shown at the same time, so its latency is PIPE+1.
- R6: With portMode = 1, dataClk is a registered half-rate clock. It is low in the cycle after an odd sample reaches the output stage and high in the cycle after an even one, so it falls exactly when a parallel pair updates.
- R7: validA goes high only after PIPE+2 clocks have passed since reset or since the last clock that saw a change in any of portMode, pairMode or swapPhase. validB also requires portMode = 1.
- R8: With pwrActive = 0, both ports are high impedance while the pipeline keeps running. When pwrActive returns to 1, the ports show their current pipelined contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsyncIn | input | 1 | Horizontal sync, active high; leading edge restarts the even/odd count |
| sampleIn | input | CH*BITS | One sample, all colour channels packed |
| portMode | input | 1 | 0 single port, 1 dual port |
| pairMode | input | 1 | Dual port only: 0 interleaved, 1 parallel pairs |
| swapPhase | input | 1 | 0 even to A, 1 even to B |
| pwrActive | input | 1 | 1 drives the ports, 0 floats them |
| portA | output | CH*BITS | Output port A, tri-state |
| portB | output | CH*BITS | Output port B, tri-state |
| dataClk | output | 1 | Data clock for the receiver |
| validA | output | 1 | Port A carries flushed data |
| validB | output | 1 | Port B carries flushed data |

## Verification
The bench builds the block with two channels of eight bits and a four-stage delay line. The short pipeline puts the flush boundary at six clocks, so the clock where validA rises after each mode change can be checked one cycle at a time. The sync line is eleven samples long, an odd number, so successive sync leading edges fall at both parities. This exercises the restart of the even/odd count in every steering mode, with both values of swapPhase.

// File: rtl/pixdemux_pkg.sv
package pixdemux_pkg;
  // Steering strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic updA;       // load port A register this clock
    logic updB;       // load port B register this clock
    logic aFromHeld;  // port A takes the held (previous) sample
    logic bFromHeld;  // port B takes the held (previous) sample
  } steerStrb_t;
endpackage

// File: rtl/pixdemux_ctrl.sv
module pixdemux_ctrl
  import pixdemux_pkg::*;
#(
  parameter int PIPE = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsyncIn,
  input  logic       portMode,
  input  logic       pairMode,
  input  logic       swapPhase,
  output steerStrb_t strb,
  output logic       divClk,
  output logic       flushed
);
  localparam int FLUSH = PIPE + 2;
  localparam int CW    = $clog2(FLUSH + 1);

  logic            hsPrev;
  logic            parReg;
  logic            parNext;
  logic [PIPE-1:0] parLine;
  logic            outPar;
  logic [2:0]      modeReg;
  logic [2:0]      modeNow;
  logic [CW-1:0]   fillCnt;

  // Even/odd index, restarted on the sync leading edge
  assign parNext = (hsyncIn && !hsPrev) ? 1'b0 : !parReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsPrev <= 1'b0;
      parReg <= 1'b0;
    end else begin
      hsPrev <= hsyncIn;
      parReg <= parNext;
    end
  end

  // Parity travels alongside the data delay line
  for (genvar s = 0; s < PIPE; s++) begin : g_par
    always_ff @(posedge clk) begin
      if (!rstN)       parLine[s] <= 1'b0;
      else if (s == 0) parLine[s] <= parNext;
      else             parLine[s] <= parLine[(s == 0) ? 0 : s-1];
    end
  end

  assign outPar = parLine[PIPE-1];

  always_comb begin
    strb = '0;
    if (!portMode) begin
      strb.updA = 1'b1;
    end else if (!pairMode) begin
      strb.updA = (outPar == swapPhase);
      strb.updB = (outPar != swapPhase);
    end else begin
      strb.updA      = outPar;
      strb.updB      = outPar;
      strb.aFromHeld = !swapPhase;
      strb.bFromHeld = swapPhase;
    end
  end

  // Half-rate data clock: falls when an odd sample is presented
  always_ff @(posedge clk) begin
    if (!rstN) divClk <= 1'b0;
    else       divClk <= !outPar;
  end

  // Flush counter restarts on any mode change
  assign modeNow = {portMode, pairMode, swapPhase};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      fillCnt <= '0;
    end else begin
      modeReg <= modeNow;
      if (modeNow != modeReg)          fillCnt <= '0;
      else if (fillCnt != CW'(FLUSH))  fillCnt <= fillCnt + 1'b1;
    end
  end

  assign flushed = (fillCnt == CW'(FLUSH));
endmodule

// File: rtl/pixdemux_data.sv
module pixdemux_data
  import pixdemux_pkg::*;
#(
  parameter int DW   = 24,
  parameter int PIPE = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] sampleIn,
  input  steerStrb_t    strb,
  input  logic          pwrActive,
  output logic [DW-1:0] portA,
  output logic [DW-1:0] portB
);
  logic [DW-1:0] line [PIPE];
  logic [DW-1:0] held;
  logic [DW-1:0] regA;
  logic [DW-1:0] regB;
  logic [DW-1:0] lineOut;

  for (genvar s = 0; s < PIPE; s++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN)       line[s] <= '0;
      else if (s == 0) line[s] <= sampleIn;
      else             line[s] <= line[(s == 0) ? 0 : s-1];
    end
  end

  assign lineOut = line[PIPE-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= '0;
      regA <= '0;
      regB <= '0;
    end else begin
      held <= lineOut;
      if (strb.updA) regA <= strb.aFromHeld ? held : lineOut;
      if (strb.updB) regB <= strb.bFromHeld ? held : lineOut;
    end
  end

  assign portA = pwrActive ? regA : 'z;
  assign portB = pwrActive ? regB : 'z;
endmodule

// File: rtl/pixel_port_demux.sv
module pixel_port_demux
  import pixdemux_pkg::*;
#(
  parameter int CH   = 3,
  parameter int BITS = 8,
  parameter int PIPE = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hsyncIn,
  input  logic [CH*BITS-1:0] sampleIn,
  input  logic               portMode,
  input  logic               pairMode,
  input  logic               swapPhase,
  input  logic               pwrActive,
  output logic [CH*BITS-1:0] portA,
  output logic [CH*BITS-1:0] portB,
  output logic               dataClk,
  output logic               validA,
  output logic               validB
);
  localparam int DW = CH * BITS;

  steerStrb_t strb;
  logic       divClk;
  logic       flushed;

  pixdemux_ctrl #(.PIPE(PIPE)) u_ctrl (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn),
    .portMode(portMode), .pairMode(pairMode), .swapPhase(swapPhase),
    .strb(strb), .divClk(divClk), .flushed(flushed)
  );

  pixdemux_data #(.DW(DW), .PIPE(PIPE)) u_data (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .strb(strb),
    .pwrActive(pwrActive), .portA(portA), .portB(portB)
  );

  assign dataClk = portMode ? divClk : !clk;
  assign validA  = flushed;
  assign validB  = flushed && portMode;
endmodule

// File: rtl/pixel_port_demux_chk.sv
module pixel_port_demux_chk
  import pixdemux_pkg::*;
#(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          portMode,
  input logic          pairMode,
  input logic          swapPhase,
  input logic          pwrActive,
  input logic [DW-1:0] portA,
  input logic [DW-1:0] portB,
  input logic          dataClk,
  input logic          validA,
  input logic          validB,
  input steerStrb_t    strb
);
  p_flush_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    ({portMode, pairMode, swapPhase} != $past({portMode, pairMode, swapPhase}))
      |=> (!validA && !validB));

  p_single_b_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !portMode |-> !validB);

  p_one_port_moves_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(portMode) && !$past(pairMode) && pwrActive && $past(pwrActive))
      |-> ($stable(portA) || $stable(portB)));

  p_pair_clk_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (portMode && $past(portMode) && $past(pairMode)
      && $past(strb.updA) && $past(strb.updB)) |-> !dataClk);
endmodule

bind pixel_port_demux pixel_port_demux_chk #(.DW(CH*BITS)) u_chk (
  .clk(clk), .rstN(rstN), .portMode(portMode), .pairMode(pairMode),
  .swapPhase(swapPhase), .pwrActive(pwrActive), .portA(portA),
  .portB(portB), .dataClk(dataClk), .validA(validA), .validB(validB),
  .strb(strb)
);

// File: tb/tb_pixel_port_demux.sv
`timescale 1ns/1ps
module tb_pixel_port_demux;
  localparam int CH    = 2;
  localparam int BITS  = 8;
  localparam int PIPE  = 4;
  localparam int DW    = CH * BITS;
  localparam int FLUSH = PIPE + 2;
  localparam int LINE  = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hsyncIn = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic          portMode = 1'b0, pairMode = 1'b0, swapPhase = 1'b0;
  logic          pwrActive = 1'b1;
  wire  [DW-1:0] portA, portB;
  wire           dataClk, validA, validB;

  int compared = 0;
  int mismatched = 0;
  int lineCnt = 0;
  int seqNo = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pixel_port_demux #(.CH(CH), .BITS(BITS), .PIPE(PIPE)) dut (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .sampleIn(sampleIn),
    .portMode(portMode), .pairMode(pairMode), .swapPhase(swapPhase),
    .pwrActive(pwrActive), .portA(portA), .portB(portB),
    .dataClk(dataClk), .validA(validA), .validB(validB)
  );

  // Expected-value model, built from the requirement text
  logic          hsPM, parM, leadM, pM, outPM;
  logic [DW-1:0] dM [PIPE];
  logic          pmM [PIPE];
  logic [DW-1:0] heldM, expA, expB, outDM;
  logic          divM;
  logic [2:0]    modeM;
  int            cntM;

  always @(posedge clk) begin
    if (!rstN) begin
      hsPM <= 0; parM <= 0; heldM <= '0; expA <= '0; expB <= '0;
      divM <= 0; modeM <= '0; cntM <= 0;
      for (int i = 0; i < PIPE; i++) begin dM[i] <= '0; pmM[i] <= 0; end
    end else begin
      leadM = hsyncIn && !hsPM;            // R2 index 0 on leading edge
      pM    = leadM ? 1'b0 : !parM;
      outDM = dM[PIPE-1];
      outPM = pmM[PIPE-1];
      hsPM <= hsyncIn; parM <= pM;
      dM[0] <= sampleIn; pmM[0] <= pM;
      for (int i = 1; i < PIPE; i++) begin dM[i] <= dM[i-1]; pmM[i] <= pmM[i-1]; end
      heldM <= outDM;
      if (!portMode) expA <= outDM;                       // R1
      else if (!pairMode) begin                           // R4 / R3
        if (outPM == swapPhase) expA <= outDM; else expB <= outDM;
      end else if (outPM) begin                           // R5 / R3
        expA <= swapPhase ? outDM : heldM;
        expB <= swapPhase ? heldM : outDM;
      end
      divM <= !outPM;                                     // R6
      modeM <= {portMode, pairMode, swapPhase};
      if ({portMode, pairMode, swapPhase} != modeM) cntM <= 0;   // R7
      else if (cntM < FLUSH) cntM <= cntM + 1;
    end
  end

  task automatic cmp(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    cmp(tag, "validA", validA, (cntM >= FLUSH));
    cmp(tag, "validB", validB, (cntM >= FLUSH) && portMode);
    cmp(tag, "dataClk", dataClk, portMode ? divM : 1'b1);
    if (pwrActive) begin
      cmp(tag, "portA", portA, expA);
      if (portMode) cmp(tag, "portB", portB, expB);
    end else begin  // R8 floating ports
      cmp(tag, "portA floats", (portA === 'z) || (portA === '0), 1);
      cmp(tag, "portB floats", (portB === 'z) || (portB === '0), 1);
    end
  endtask

  // Advance n clocks; check after each edge, then drive the next inputs
  task automatic run(int n, bit chk, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (chk && rstN) checkAll(tag);
      seqNo++;
      sampleIn <= DW'((seqNo * 37 + 11) ^ (seqNo << 9));
      hsyncIn  <= (lineCnt < 2);
      lineCnt  = (lineCnt + 1) % LINE;
    end
  endtask

  task automatic setMode(bit pm, bit pr, bit sw);
    @(negedge clk); #1;
    portMode <= pm; pairMode <= pr; swapPhase <= sw;
  endtask

  task automatic t_reset;
    run(4, 0, "R7");
    rstN <= 1'b1;
    @(negedge clk); #1;
    cmp("R7 reset", "validA", validA, 0);
    cmp("R7 reset", "validB", validB, 0);
    cmp("R7 reset", "portA", portA, 0);
    run(2 * LINE, 1, "R7 post-reset");
  endtask

  task automatic t_single;
    setMode(0, 0, 0);
    run(3 * LINE, 1, "R1 single");
  endtask

  task automatic t_interleave(bit sw);
    setMode(1, 0, sw);
    run(3 * LINE, 1, sw ? "R3 R4 swapped interleave" : "R2 R4 interleave");
  endtask

  task automatic t_parallel(bit sw);
    setMode(1, 1, sw);
    run(3 * LINE, 1, sw ? "R3 R5 R6 swapped pairs" : "R5 R6 pairs");
  endtask

  // Exact flush boundary after a mode change
  task automatic t_flush;
    setMode(1, 1, 0);
    run(FLUSH + 2, 0, "R7");
    @(negedge clk); #1;
    portMode <= 1'b0;
    for (int j = 0; j <= FLUSH + 1; j++) begin
      @(negedge clk); #1;
      cmp("R7 flush", "validA", validA, (j >= FLUSH));
      cmp("R7 flush", "validB", validB, 0);
    end
  endtask

  task automatic t_power;
    setMode(1, 0, 0);
    run(FLUSH + 2, 1, "R8 before");
    pwrActive <= 1'b0;
    run(LINE, 1, "R8 floating");
    pwrActive <= 1'b1;
    run(LINE, 1, "R8 restored");
  endtask

  initial begin
    t_reset();
    t_single();
    t_interleave(0);
    t_interleave(1);
    t_parallel(0);
    t_parallel(1);
    t_flush();
    t_power();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule